// File: doc/BRIEF.md
# Flash OTP Page Fetch Sequencer

This block is a host-side controller for a NAND-style flash device that exposes its control registers on a 16-bit memory-mapped bus. On a start request it runs a fixed register script. The script switches the device into its one-time-programmable area by command. It waits for the device interrupt bit, writes the chosen page and sector, and points the device's buffer window at the sector used for that area. It then launches a load, waits for the interrupt again, reads the loaded words back out of the buffer and passes them to the requester one word at a time.

The device stays in OTP mode until it is reset. For that reason the sequencer always ends a request with a core reset command, including after a failed wait. Each interrupt wait is bounded by a cycle limit. When the limit runs out, the wait is abandoned, an error flag is raised and the script jumps straight to the exit reset. An option input leaves out the two interrupt-clear writes, for devices that clear the interrupt on their own.

Top module: `otp_page_fetch`

## Requirements
- R1: After reset the sequencer is idle: reg_wr, reg_rd, busy, done and timeout_err are all low.
- R2: A request issues these writes in this order: F100h ← {DIE_SEL, 15'b0}; F220h ← 0065h; first interrupt wait; F107h ← {8'h00, page_sel[5:0], sector_sel[1:0]}; F200h ← 0800h; F220h ← 0000h; second interrupt wait.
- R3: A bus transfer keeps reg_wr, reg_rd, reg_addr and reg_wdata steady until a cycle with reg_ready high. reg_wr and reg_rd are never high together. The only exception is a wait read that is dropped by a timeout.
- R4: An interrupt wait reads F241h repeatedly. It ends at the first completed read that returns bit 15 = 1 after a read in the same wait that returned bit 15 = 0. A stale 1 seen before any 0 does not end the wait.
- R5: With skip_clear low at start, a write of 0000h to F241h comes right before each of the two command writes to F220h. With skip_clear high, neither clear write is issued.
- R6: After the second wait, WORDS reads are issued from BUF_BASE upward. Each completed read shows its data on dout with dout_valid high for exactly the following cycle.
- R7: After the last buffer read, EXIT_CMD is written to F220h. done is high for one cycle, the cycle after that write completes, and busy falls in the same cycle.
- R8: If a wait has not ended after TIMEOUT_CYC cycles, the sequencer skips to the EXIT_CMD write. timeout_err rises when that write begins and stays high until the next accepted start.
- R9: start, page_sel, sector_sel and skip_clear are sampled only while idle. A start during a request changes nothing on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a page fetch (sampled when idle) |
| page_sel | input | 6 | Page inside the OTP area |
| sector_sel | input | 2 | Sector inside the page |
| skip_clear | input | 1 | Leave out the interrupt-clear writes |
| reg_addr | output | 16 | Register bus address |
| reg_wdata | output | 16 | Register bus write data |
| reg_wr | output | 1 | Write strobe, held until ready |
| reg_rd | output | 1 | Read strobe, held until ready |
| reg_rdata | input | 16 | Read data, valid with reg_ready on a read |
| reg_ready | input | 1 | Transfer completes in this cycle |
| dout | output | 16 | Fetched buffer word |
| dout_valid | output | 1 | dout holds a new word |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when the exit reset has been written |
| timeout_err | output | 1 | The last request ended by timeout |

## Verification
On every cycle the assertions check the bus handshake: strobes are held steady under back-pressure and never overlap. They also check that the request fields stay frozen while busy, that done is a single-cycle pulse that follows only a completed exit write, and that dout_valid follows only a completed buffer read. A rise of timeout_err is allowed only out of a wait. Some behaviour can only be shown by the bench's scenarios, which compare every transfer against a reference script: the exact order and values of the writes, the effect of skip_clear, the edge rule of the interrupt wait when a stale high is present, the exact timeout length, the streamed words, and the clearing of the error flag by the next start.

// File: rtl/otp_page_fetch.sv
module otp_page_fetch #(
  parameter logic        DIE_SEL     = 1'b0,
  parameter logic [15:0] BUF_BASE    = 16'h0400,
  parameter int          WORDS       = 256,
  parameter int          TIMEOUT_CYC = 4096,
  parameter logic [15:0] EXIT_CMD    = 16'h00F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  page_sel,
  input  logic [1:0]  sector_sel,
  input  logic        skip_clear,
  output logic [15:0] reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_wr,
  output logic        reg_rd,
  input  logic [15:0] reg_rdata,
  input  logic        reg_ready,
  output logic [15:0] dout,
  output logic        dout_valid,
  output logic        busy,
  output logic        done,
  output logic        timeout_err
);

  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [15:0] A_SEL  = 16'hF100;
  localparam logic [15:0] A_PAGE = 16'hF107;
  localparam logic [15:0] A_WIN  = 16'hF200;
  localparam logic [15:0] A_CMD  = 16'hF220;
  localparam logic [15:0] A_INT  = 16'hF241;
  localparam logic [15:0] C_OTP  = 16'h0065;
  localparam logic [15:0] C_LOAD = 16'h0000;
  localparam logic [15:0] WIN_V  = 16'h0800;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_CLR1, S_OTP, S_POLL1, S_PAGE, S_WIN,
    S_CLR2, S_LOAD, S_POLL2, S_RD, S_EXIT
  } st_t;

  st_t           state, nxt;
  logic [5:0]    pg_q;
  logic [1:0]    sc_q;
  logic          skip_q;
  logic [IW-1:0] idx;
  logic [TW-1:0] tcnt;
  logic          seen_low;
  logic [15:0]   dout_q;
  logic          dval_q, done_q, err_q;

  wire xfer    = reg_ready && (reg_wr || reg_rd);
  wire polling = (state == S_POLL1) || (state == S_POLL2);
  wire rise    = polling && xfer && reg_rdata[15] && seen_low;
  wire expire  = polling && !rise && (tcnt == TW'(TIMEOUT_CYC - 1));
  wire last_rd = (idx == IW'(WORDS - 1));
  wire accept  = (state == S_IDLE) && start;

  always_comb begin
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_addr  = 16'h0000;
    reg_wdata = 16'h0000;
    case (state)
      S_SEL:   begin reg_wr = 1'b1; reg_addr = A_SEL;  reg_wdata = {DIE_SEL, 15'b0}; end
      S_CLR1,
      S_CLR2:  begin reg_wr = 1'b1; reg_addr = A_INT;  reg_wdata = 16'h0000; end
      S_OTP:   begin reg_wr = 1'b1; reg_addr = A_CMD;  reg_wdata = C_OTP; end
      S_PAGE:  begin reg_wr = 1'b1; reg_addr = A_PAGE; reg_wdata = {8'h00, pg_q, sc_q}; end
      S_WIN:   begin reg_wr = 1'b1; reg_addr = A_WIN;  reg_wdata = WIN_V; end
      S_LOAD:  begin reg_wr = 1'b1; reg_addr = A_CMD;  reg_wdata = C_LOAD; end
      S_EXIT:  begin reg_wr = 1'b1; reg_addr = A_CMD;  reg_wdata = EXIT_CMD; end
      S_POLL1,
      S_POLL2: begin reg_rd = 1'b1; reg_addr = A_INT; end
      S_RD:    begin reg_rd = 1'b1; reg_addr = BUF_BASE + 16'(idx); end
      default: ;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (start) nxt = S_SEL;
      S_SEL:   if (xfer) nxt = skip_q ? S_OTP : S_CLR1;
      S_CLR1:  if (xfer) nxt = S_OTP;
      S_OTP:   if (xfer) nxt = S_POLL1;
      S_POLL1: if (rise) nxt = S_PAGE; else if (expire) nxt = S_EXIT;
      S_PAGE:  if (xfer) nxt = S_WIN;
      S_WIN:   if (xfer) nxt = skip_q ? S_LOAD : S_CLR2;
      S_CLR2:  if (xfer) nxt = S_LOAD;
      S_LOAD:  if (xfer) nxt = S_POLL2;
      S_POLL2: if (rise) nxt = S_RD; else if (expire) nxt = S_EXIT;
      S_RD:    if (xfer && last_rd) nxt = S_EXIT;
      S_EXIT:  if (xfer) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pg_q     <= '0;
      sc_q     <= '0;
      skip_q   <= 1'b0;
      idx      <= '0;
      tcnt     <= '0;
      seen_low <= 1'b0;
      dout_q   <= '0;
      dval_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        pg_q   <= page_sel;
        sc_q   <= sector_sel;
        skip_q <= skip_clear;
      end
      if (state != S_RD) idx <= '0;
      else if (xfer)     idx <= idx + 1'b1;
      if (!polling) begin
        tcnt     <= '0;
        seen_low <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
        if (xfer && !reg_rdata[15]) seen_low <= 1'b1;
      end
      dval_q <= (state == S_RD) && xfer;
      if ((state == S_RD) && xfer) dout_q <= reg_rdata;
      done_q <= (state == S_EXIT) && xfer;
      if (accept)      err_q <= 1'b0;
      else if (expire) err_q <= 1'b1;
    end
  end

  assign dout        = dout_q;
  assign dout_valid  = dval_q;
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_wr && !reg_rd));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && !reg_ready && !expire) |=>
      ($stable(reg_addr) && $stable(reg_wdata) && $stable(reg_wr) && $stable(reg_rd)));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_valid_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(reg_rd && reg_ready && reg_addr != A_INT));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(reg_wr && reg_ready && reg_addr == A_CMD && reg_wdata == EXIT_CMD) && !busy));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(reg_rd && reg_addr == A_INT));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(pg_q) && $stable(sc_q) && $stable(skip_q))));

endmodule

// File: tb/test_otp_page_fetch.sv
`timescale 1ns/1ps
module test_otp_page_fetch;
  localparam logic        DIE  = 1'b1;
  localparam logic [15:0] BASE = 16'h0400;
  localparam int          NW   = 8;
  localparam int          TO   = 64;
  localparam logic [15:0] XCMD = 16'h00F0;
  localparam int K_WR = 0, K_RD = 1, K_POLL = 2, K_PTO = 3;

  typedef struct {
    int kind; logic [15:0] addr; logic [15:0] data; string tag;
    int pre; int lows; int nrd; int cnt; bit is_exit;
  } item_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, skip_clear = 1'b0;
  logic [5:0] page_sel = '0;
  logic [1:0] sector_sel = '0;
  logic [15:0] reg_addr, reg_wdata, dout;
  logic reg_wr, reg_rd, dout_valid, busy, done, timeout_err;
  logic [15:0] reg_rdata = '0;
  logic reg_ready = 1'b0;

  otp_page_fetch #(.DIE_SEL(DIE), .BUF_BASE(BASE), .WORDS(NW), .TIMEOUT_CYC(TO), .EXIT_CMD(XCMD))
  i_otp_page_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel), .sector_sel(sector_sel),
    .skip_clear(skip_clear), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_ready(reg_ready), .dout(dout),
    .dout_valid(dout_valid), .busy(busy), .done(done), .timeout_err(timeout_err));

  item_t q[$];
  logic [15:0] dq[$];
  int errors = 0, checks = 0;
  bit exp_done = 0, exp_err = 0, mon_on = 0, rnd_ready = 0;
  logic [7:0] lfsr = 8'h5A;

  function automatic logic [15:0] buf_word(logic [15:0] a);
    return (a * 16'd37) ^ 16'hC3A5;
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int kind, logic [15:0] a, logic [15:0] d, string tag, int pre, int lows, bit ex);
    item_t it;
    it.kind = kind; it.addr = a; it.data = d; it.tag = tag;
    it.pre = pre; it.lows = lows; it.nrd = 0; it.cnt = 0; it.is_exit = ex;
    q.push_back(it);
  endtask

  task automatic build(logic [5:0] pg, logic [1:0] sc, bit skip,
                       bit to1, int pre1, int lows1, bit to2, int pre2, int lows2);
    push(K_WR, 16'hF100, {DIE, 15'b0}, "R2", 0, 0, 0);
    if (!skip) push(K_WR, 16'hF241, 16'h0000, "R5", 0, 0, 0);
    push(K_WR, 16'hF220, 16'h0065, "R2", 0, 0, 0);
    if (to1) begin
      push(K_PTO, 16'hF241, 0, "R8", 0, 0, 0);
      push(K_WR, 16'hF220, XCMD, "R8", 0, 0, 1);
      return;
    end
    push(K_POLL, 16'hF241, 0, "R4", pre1, lows1, 0);
    push(K_WR, 16'hF107, {8'h00, pg, sc}, "R2", 0, 0, 0);
    push(K_WR, 16'hF200, 16'h0800, "R2", 0, 0, 0);
    if (!skip) push(K_WR, 16'hF241, 16'h0000, "R5", 0, 0, 0);
    push(K_WR, 16'hF220, 16'h0000, "R2", 0, 0, 0);
    if (to2) begin
      push(K_PTO, 16'hF241, 0, "R8", 0, 0, 0);
      push(K_WR, 16'hF220, XCMD, "R8", 0, 0, 1);
      return;
    end
    push(K_POLL, 16'hF241, 0, "R4", pre2, lows2, 0);
    for (int i = 0; i < NW; i++) push(K_RD, BASE + 16'(i), 0, "R6", 0, 0, 0);
    push(K_WR, 16'hF220, XCMD, "R7", 0, 0, 1);
  endtask

  always @(negedge clk) begin
    logic rdy;
    item_t h;
    reg_ready = 1'b0;
    reg_rdata = 16'h0000;
    if (mon_on) begin
      if (dout_valid) begin
        if (dq.size() == 0) chk(0, "R6", dout, 16'h0000);
        else begin
          logic [15:0] e;
          e = dq.pop_front();
          chk(dout == e, "R6", dout, e);
        end
      end
      chk(done == exp_done, "R7", {15'b0, done}, {15'b0, exp_done});
      exp_done = 0;
      chk(busy == (q.size() != 0), "R9", {15'b0, busy}, {15'b0, q.size() != 0});
      if (reg_wr || reg_rd) begin
        rdy = rnd_ready ? lfsr[0] : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        for (int pass = 0; pass < 2; pass++) begin
          if (q.size() == 0) begin
            chk(0, "R9", reg_addr, 16'hFFFF);
            break;
          end
          h = q[0];
          if (h.kind == K_PTO) begin
            if (reg_rd && reg_addr == 16'hF241) begin
              h.cnt++;
              q[0] = h;
              if (h.cnt > TO) begin
                chk(0, "R8", 16'(h.cnt), 16'(TO));
                void'(q.pop_front());
              end
              reg_ready = rdy;
              break;
            end
            chk(h.cnt == TO, "R8", 16'(h.cnt), 16'(TO));
            exp_err = 1;
            void'(q.pop_front());
            continue;
          end
          if (h.kind == K_POLL) begin
            if (!(reg_rd && reg_addr == 16'hF241)) begin
              chk(0, "R4", reg_addr, 16'hF241);
              void'(q.pop_front());
              break;
            end
            reg_ready = rdy;
            if (rdy) begin
              reg_rdata = (h.nrd < h.pre) ? 16'h8000 :
                          (h.nrd < h.pre + h.lows) ? 16'h0000 : 16'h8000;
              h.nrd++;
              q[0] = h;
              if (h.nrd == h.pre + h.lows + 1) begin
                chk(1, "R4", 16'(h.nrd), 16'(h.nrd));
                void'(q.pop_front());
              end
            end
            break;
          end
          reg_ready = rdy;
          if (rdy) begin
            if (h.kind == K_WR) begin
              chk(reg_wr && !reg_rd && reg_addr == h.addr, h.tag, reg_addr, h.addr);
              chk(reg_wdata == h.data, h.tag, reg_wdata, h.data);
              if (h.is_exit) exp_done = 1;
            end else begin
              chk(reg_rd && !reg_wr && reg_addr == h.addr, h.tag, reg_addr, h.addr);
              reg_rdata = buf_word(reg_addr);
              dq.push_back(reg_rdata);
            end
            void'(q.pop_front());
          end
          break;
        end
      end
      chk(timeout_err == exp_err, "R8", {15'b0, timeout_err}, {15'b0, exp_err});
    end
  end

  task automatic run(logic [5:0] pg, logic [1:0] sc, bit skip, bit rnd,
                     bit to1, int pre1, int lows1, bit to2, int pre2, int lows2, bit poke);
    @(negedge clk); #1;
    rnd_ready = rnd;
    build(pg, sc, skip, to1, pre1, lows1, to2, pre2, lows2);
    exp_err = 0;
    page_sel = pg; sector_sel = sc; skip_clear = skip; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    page_sel = ~pg; sector_sel = ~sc; skip_clear = ~skip;
    if (poke) begin
      repeat (2) @(negedge clk);
      #1 start = 1'b1;
      repeat (5) @(negedge clk);
      #1 start = 1'b0;
    end
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    #2 chk(!reg_wr && !reg_rd && !busy && !done && !timeout_err, "R1",
           {11'b0, reg_wr, reg_rd, busy, done, timeout_err}, 16'h0000);
    @(negedge clk); #1 mon_on = 1;
    run(6'd5,  2'd2, 0, 0, 0, 0, 2, 0, 0, 1, 0);
    run(6'd17, 2'd1, 1, 1, 0, 2, 1, 0, 1, 3, 0);
    run(6'd63, 2'd3, 0, 1, 0, 0, 1, 0, 0, 1, 1);
    run(6'd9,  2'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    run(6'd3,  2'd3, 1, 0, 0, 1, 2, 1, 0, 0, 0);
    run(6'd1,  2'd0, 0, 1, 0, 0, 1, 0, 2, 2, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule